// File: doc/BRIEF.md
# Table-Indexed Jump Unit

This block executes the compact table-jump instructions of a 32-bit processor. When the pipeline presents a start strobe, it also supplies an 8-bit table index, the current value of the jump-table control register and the program counter of the instruction. The unit first checks the control register. If the control register allows the jump, the unit computes the address of one table entry and reads that word through a valid/ready request port. The word it reads back becomes the branch target.

Index values below a split point select the plain jump. Higher index values select the linking jump, which also writes the return address into register x1. The return address is the instruction's program counter plus the 2-byte instruction length. A nonzero mode field in the control register makes the instruction illegal. An access fault on the read response becomes an exception. In both of these cases the unit produces no redirect and no register write.

All results appear together in one cycle, marked by a single-cycle done pulse. The pipeline holds the instruction until that pulse arrives.

Top module: `jt_jump_unit`

## Requirements
- R1: After reset, `done_o`, `redirect_valid_o`, `link_we_o`, `illegal_o`, `access_fault_o`, `mem_req_valid_o` and `busy_o` are all 0.
- R2: A start taken while bits [5:0] of `jvt_i` are nonzero produces, on the next cycle, `done_o`=1 and `illegal_o`=1. On that cycle there is no memory request, no redirect and no link write.
- R3: A start taken with mode bits zero raises `mem_req_valid_o` on the next cycle. `mem_req_addr_o` = (`jvt_i` with bits [5:0] cleared) + 4 × `index_i`, computed modulo 2^32.
- R4: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and its address does not change.
- R5: The cycle after a response handshake with no fault, `done_o` and `redirect_valid_o` are 1 and `redirect_pc_o` equals the returned word. `done_o` is high for exactly one cycle.
- R6: When `index_i` ≥ 32, the done cycle also carries `link_we_o`=1, `link_rd_o`=1 and `link_data_o` = `pc_i` + 2. When `index_i` < 32, `link_we_o` stays 0.
- R7: A response with `mem_rsp_fault_i`=1 produces `done_o`=1 and `access_fault_o`=1, with `redirect_valid_o`=0 and `link_we_o`=0.
- R8: While `busy_o` is 1, a start strobe is ignored. The results of the current instruction are unchanged, and no further request follows.
- R9: Exactly one memory request is issued per accepted legal start. `mem_req_valid_o` falls in the cycle after the request handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one table-jump instruction |
| index_i | input | 8 | Table index taken from the instruction |
| jvt_i | input | 32 | Jump-table control register: base address in bits [31:6], mode in bits [5:0] |
| pc_i | input | 32 | Program counter of the instruction |
| busy_o | output | 1 | An instruction is in flight or its results are being shown |
| mem_req_valid_o | output | 1 | Table entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Byte address of the table entry |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Table entry word |
| mem_rsp_fault_i | input | 1 | Access fault on the read |
| done_o | output | 1 | One-cycle completion pulse |
| redirect_valid_o | output | 1 | Branch redirect to `redirect_pc_o` |
| redirect_pc_o | output | 32 | Target address |
| link_we_o | output | 1 | Write `link_data_o` to register `link_rd_o` |
| link_rd_o | output | 5 | Link destination register number (always 1) |
| link_data_o | output | 32 | Return address |
| illegal_o | output | 1 | Illegal-instruction exception (nonzero mode) |
| access_fault_o | output | 1 | Access-fault exception from the table read |

## Verification
The assertions check the following on every cycle:
- a pending request holds steady while stalled;
- the done pulse lasts one cycle;
- an illegal or faulted instruction never carries a redirect or a link write;
- a link write never appears without a redirect;
- a bad mode taken at start always leads to the illegal flag.

Only the bench's scenarios can show the rest:
- that the entry address and return address are the right values;
- that the redirect target is the word returned by memory;
- that the split between the plain and linking forms falls at index 32;
- that a start arriving mid-flight leaves the current results untouched.

// File: rtl/jt_pkg.sv
package jt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } jt_state_e;

    typedef struct packed {
        jt_state_e   st;
        logic [31:0] addr;
        logic        link;
        logic [31:0] link_val;
        logic        done;
        logic        redir;
        logic [31:0] tgt;
        logic        lwe;
        logic        ill;
        logic        flt;
    } jt_regs_t;
endpackage

// File: rtl/jt_decode.sv
module jt_decode #(
    parameter int XLEN       = 32,
    parameter int IDX_W      = 8,
    parameter int MODE_W     = 6,
    parameter int LINK_SPLIT = 32,
    parameter int INSN_BYTES = 2
) (
    input  logic [IDX_W-1:0] index_i,
    input  logic [XLEN-1:0]  jvt_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic             mode_bad_o,
    output logic [XLEN-1:0]  entry_addr_o,
    output logic             is_link_o,
    output logic [XLEN-1:0]  link_val_o
);
    localparam int WORD_SHIFT = $clog2(XLEN / 8);

    logic [XLEN-1:0] base_d;
    logic [XLEN-1:0] offs_d;

    always_comb begin
        mode_bad_o   = |jvt_i[MODE_W-1:0];
        base_d       = {jvt_i[XLEN-1:MODE_W], {MODE_W{1'b0}}};
        offs_d       = XLEN'(index_i) << WORD_SHIFT;
        entry_addr_o = base_d + offs_d;
        is_link_o    = (int'(index_i) >= LINK_SPLIT);
        link_val_o   = pc_i + XLEN'(INSN_BYTES);
    end
endmodule

// File: rtl/jt_seq.sv
module jt_seq
    import jt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            mode_bad_i,
    input  logic [XLEN-1:0] entry_addr_i,
    input  logic            is_link_i,
    input  logic [XLEN-1:0] link_val_i,
    output logic            busy_o,
    output logic            mem_req_valid_o,
    input  logic            mem_req_ready_i,
    output logic [XLEN-1:0] mem_req_addr_o,
    input  logic            mem_rsp_valid_i,
    input  logic [XLEN-1:0] mem_rsp_data_i,
    input  logic            mem_rsp_fault_i,
    output logic            done_o,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            illegal_o,
    output logic            access_fault_o
);
    jt_regs_t r_d, r_q;
    logic     accept_d;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.redir = 1'b0;
        r_d.lwe   = 1'b0;
        r_d.ill   = 1'b0;
        r_d.flt   = 1'b0;
        accept_d  = start_i && (r_q.st == ST_IDLE) && !r_q.done;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept_d) begin
                    if (mode_bad_i) begin
                        r_d.done = 1'b1;
                        r_d.ill  = 1'b1;
                    end else begin
                        r_d.st       = ST_REQ;
                        r_d.addr     = entry_addr_i;
                        r_d.link     = is_link_i;
                        r_d.link_val = link_val_i;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.flt   = mem_rsp_fault_i;
                    r_d.redir = !mem_rsp_fault_i;
                    r_d.lwe   = !mem_rsp_fault_i && r_q.link;
                    r_d.tgt   = mem_rsp_data_i;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o           = (r_q.st != ST_IDLE) || r_q.done;
    assign mem_req_valid_o  = (r_q.st == ST_REQ);
    assign mem_req_addr_o   = r_q.addr;
    assign done_o           = r_q.done;
    assign redirect_valid_o = r_q.redir;
    assign redirect_pc_o    = r_q.tgt;
    assign link_we_o        = r_q.lwe;
    assign link_data_o      = r_q.link_val;
    assign illegal_o        = r_q.ill;
    assign access_fault_o   = r_q.flt;

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
    a_r9_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o && !redirect_valid_o && !link_we_o && !mem_req_valid_o);
    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        access_fault_o |-> done_o && !redirect_valid_o && !link_we_o);
    a_r6_link_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> redirect_valid_o);
    a_r5_results_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o || illegal_o || access_fault_o |-> done_o);
    a_r2_mode_check: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && mode_bad_i |=> illegal_o);
endmodule

// File: rtl/jt_jump_unit.sv
module jt_jump_unit #(
    parameter int XLEN       = 32,
    parameter int IDX_W      = 8,
    parameter int MODE_W     = 6,
    parameter int LINK_SPLIT = 32,
    parameter int INSN_BYTES = 2,
    parameter int LINK_REG   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] index_i,
    input  logic [XLEN-1:0]  jvt_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic             busy_o,
    output logic             mem_req_valid_o,
    input  logic             mem_req_ready_i,
    output logic [XLEN-1:0]  mem_req_addr_o,
    input  logic             mem_rsp_valid_i,
    input  logic [XLEN-1:0]  mem_rsp_data_i,
    input  logic             mem_rsp_fault_i,
    output logic             done_o,
    output logic             redirect_valid_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic             link_we_o,
    output logic [4:0]       link_rd_o,
    output logic [XLEN-1:0]  link_data_o,
    output logic             illegal_o,
    output logic             access_fault_o
);
    logic            mode_bad;
    logic [XLEN-1:0] entry_addr;
    logic            is_link;
    logic [XLEN-1:0] link_val;

    jt_decode #(
        .XLEN(XLEN), .IDX_W(IDX_W), .MODE_W(MODE_W),
        .LINK_SPLIT(LINK_SPLIT), .INSN_BYTES(INSN_BYTES)
    ) u_dec (
        .index_i(index_i), .jvt_i(jvt_i), .pc_i(pc_i),
        .mode_bad_o(mode_bad), .entry_addr_o(entry_addr),
        .is_link_o(is_link), .link_val_o(link_val)
    );

    jt_seq #(.XLEN(XLEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mode_bad_i(mode_bad), .entry_addr_i(entry_addr),
        .is_link_i(is_link), .link_val_i(link_val),
        .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .mem_rsp_fault_i(mem_rsp_fault_i), .done_o(done_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .link_we_o(link_we_o), .link_data_o(link_data_o),
        .illegal_o(illegal_o), .access_fault_o(access_fault_o)
    );

    assign link_rd_o = 5'(LINK_REG);
endmodule

// File: tb/jt_jump_unit_tb_top.sv
module jt_jump_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  index_i = '0;
    logic [31:0] jvt_i = '0;
    logic [31:0] pc_i = '0;
    logic        busy_o, mem_req_valid_o, done_o, redirect_valid_o;
    logic        link_we_o, illegal_o, access_fault_o;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_rsp_valid_i = 1'b0;
    logic        mem_rsp_fault_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic [31:0] mem_req_addr_o, redirect_pc_o, link_data_o;
    logic [4:0]  link_rd_o;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;

    always #4 clk = ~clk;

    jt_jump_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i),
        .jvt_i(jvt_i), .pc_i(pc_i), .busy_o(busy_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_fault_i(mem_rsp_fault_i),
        .done_o(done_o), .redirect_valid_o(redirect_valid_o),
        .redirect_pc_o(redirect_pc_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .link_data_o(link_data_o),
        .illegal_o(illegal_o), .access_fault_o(access_fault_o)
    );

    function automatic logic [31:0] exp_addr(logic [31:0] jvt, logic [7:0] idx);
        return {jvt[31:6], 6'b0} + {22'b0, idx, 2'b00};
    endfunction

    function automatic logic [31:0] table_word(logic [31:0] addr);
        return (addr * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", 32'(cycles), 32'd150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_op(input logic [7:0] idx, input logic [31:0] jvt, input logic [31:0] pc,
                         input bit fault, input int rdy_dly, input int rsp_dly, input bit intrude);
        logic [31:0] ea;
        logic [31:0] w;
        bit          lk;
        ea = exp_addr(jvt, idx);
        w  = table_word(ea);
        lk = (idx >= 8'd32);
        @(negedge clk);
        start_i = 1'b1; index_i = idx; jvt_i = jvt; pc_i = pc;
        @(negedge clk);
        start_i = 1'b0;
        if (jvt[5:0] != 6'd0) begin
            chk(done_o && illegal_o, "R2 illegal", {30'b0, done_o, illegal_o}, 32'h3);
            chk(!redirect_valid_o && !link_we_o && !mem_req_valid_o, "R2 quiet",
                {29'b0, redirect_valid_o, link_we_o, mem_req_valid_o}, 32'h0);
            @(negedge clk);
            chk(!done_o && !mem_req_valid_o, "R5 pulse after illegal", {31'b0, done_o}, 32'h0);
            return;
        end
        chk(mem_req_valid_o, "R3 req valid", {31'b0, mem_req_valid_o}, 32'h1);
        chk(mem_req_addr_o == ea, "R3 entry addr", mem_req_addr_o, ea);
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            chk(mem_req_valid_o && mem_req_addr_o == ea, "R4 stall hold", mem_req_addr_o, ea);
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        chk(!mem_req_valid_o, "R9 single req", {31'b0, mem_req_valid_o}, 32'h0);
        for (int i = 0; i < rsp_dly; i++) begin
            if (intrude && i == 0) begin
                start_i = 1'b1; index_i = idx ^ 8'h80; jvt_i = jvt ^ 32'h0000_1000;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk(!done_o && !mem_req_valid_o, "R8 no action while busy", {31'b0, done_o}, 32'h0);
        end
        mem_rsp_valid_i = 1'b1; mem_rsp_data_i = w; mem_rsp_fault_i = fault;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0; mem_rsp_fault_i = 1'b0;
        chk(done_o, "R5 done", {31'b0, done_o}, 32'h1);
        if (fault) begin
            chk(access_fault_o && !redirect_valid_o && !link_we_o, "R7 fault",
                {29'b0, access_fault_o, redirect_valid_o, link_we_o}, 32'h4);
        end else begin
            chk(redirect_valid_o && redirect_pc_o == w, "R5 redirect", redirect_pc_o, w);
            chk(link_we_o == lk, "R6 link select", {31'b0, link_we_o}, {31'b0, lk});
            if (lk) begin
                chk(link_rd_o == 5'd1 && link_data_o == pc + 32'd2, "R6 link value",
                    link_data_o, pc + 32'd2);
            end
            chk(!access_fault_o && !illegal_o, "R7 no spurious flag",
                {30'b0, access_fault_o, illegal_o}, 32'h0);
        end
        @(negedge clk);
        chk(!done_o && !mem_req_valid_o && !busy_o, "R5 single pulse / R8 no extra req",
            {29'b0, done_o, mem_req_valid_o, busy_o}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!done_o && !redirect_valid_o && !link_we_o && !illegal_o && !access_fault_o
            && !mem_req_valid_o && !busy_o, "R1 reset state",
            {25'b0, done_o, redirect_valid_o, link_we_o, illegal_o, access_fault_o,
             mem_req_valid_o, busy_o}, 32'h0);
        rst_n = 1'b1;
        // directed corners
        do_op(8'd0,   32'h8000_0000, 32'h0000_1000, 1'b0, 0, 0, 1'b0);
        do_op(8'd31,  32'h8000_0040, 32'h0000_2000, 1'b0, 2, 1, 1'b0);
        do_op(8'd32,  32'h8000_0000, 32'h0000_3002, 1'b0, 1, 2, 1'b0);
        do_op(8'd255, 32'hFFFF_FFC0, 32'hFFFF_FFFE, 1'b0, 0, 0, 1'b0);
        do_op(8'd5,   32'h8000_0001, 32'h0000_4000, 1'b0, 0, 0, 1'b0);
        do_op(8'd40,  32'h8000_0020, 32'h0000_4000, 1'b0, 0, 0, 1'b0);
        do_op(8'd40,  32'h9000_0000, 32'h0000_5000, 1'b1, 1, 1, 1'b0);
        do_op(8'd7,   32'h9000_0000, 32'h0000_6000, 1'b0, 1, 3, 1'b1);
        do_op(8'd100, 32'h9000_0000, 32'h0000_6000, 1'b0, 0, 2, 1'b1);
        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [31:0] j;
            j = $urandom();
            if ($urandom_range(5, 0) != 0) j[5:0] = 6'd0;
            do_op(8'($urandom()), j, {$urandom()} & 32'hFFFF_FFFE, ($urandom_range(7, 0) == 0),
                  int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
                  ($urandom_range(3, 0) == 0));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule